// File: doc/BRIEF.md
# Thread Run-Enable and Park Control

This block decides which hardware threads of one core may run. Software writes a run-enable mask with one bit per thread through a small register port. A thread whose bit is 0 sees its park request raised. It then drains and answers with a parked acknowledge after its own delay. A second register, which software can only read, shows the run state that the threads have actually reached. That status follows the acknowledges, so it lags the requested mask while a park or unpark is in flight. Once the threads have settled, it reads the same as the mask.

The block refuses to let software stop the whole core. A write whose thread bits are all zero is dropped, so at least one thread is always enabled. A thread can park its siblings by writing a mask that holds only its own bit. It brings them back by writing their bits as 1 again.

Top module: `thread_run_ctrl`

## Requirements
- R1: After reset both registers read the reset mask (all ones by default, `8'hFF` for 8 threads), and every `park_req` bit is 0.
- R2: A write with `reg_addr = 0` (run-enable) whose low NTHREADS data bits are not all zero loads those bits into run-enable on the clock edge that samples the strobe. A read in the same cycle returns the old value.
- R3: A write to run-enable whose low NTHREADS data bits are all zero is ignored. Run-enable and status both keep their previous values.
- R4: `park_req[i]` is 1 exactly when run-enable bit i is 0. It changes in the cycle after the write edge.
- R5: Status bit i is the inverse of `parked_ack[i]` as sampled on the previous clock edge, so status lags run-enable while threads drain.
- R6: Once every thread's acknowledge matches its request, a read of status (`reg_addr = 1`) returns the same value as a read of run-enable (`reg_addr = 0`).
- R7: Read data bits at or above NTHREADS are always 0, and write data bits at or above NTHREADS have no effect.
- R8: A write with `reg_addr = 1` (status) changes neither register.
- R9: Writing a parked thread's bit back to 1 drops its `park_req`. Its status bit returns to 1 one cycle after its acknowledge falls.
- R10: Reads are combinational. `reg_addr = 0` selects run-enable and `reg_addr = 1` selects status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 1 | Register select: 0 run-enable, 1 status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| park_req | output | NTHREADS | Per-thread request to stop |
| parked_ack | input | NTHREADS | Per-thread indication that the thread has stopped |

## Verification
Each result is due at a known point:
- A write is due in run-enable and `park_req` in the cycle right after the edge that samples it.
- A change on an acknowledge reaches status one edge later.
- Read data is valid in the same cycle as the address.

The bench drives inputs on the falling edge and samples one time unit later. It compares against a model that moves to its next state only at the rising edge. Because of this, a same-cycle read must see the old value, and status must still show the pre-park value right after a park write.

The bench's thread models acknowledge after different delays for each thread. This makes it possible to observe the lag window and the later convergence of the two registers.

// File: rtl/thread_run_pkg.sv
package thread_run_pkg;

    typedef enum logic {
        SEL_RUN  = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } reg_cmd_t;

    function automatic reg_cmd_t decode_cmd(input logic wr, input logic addr);
        reg_cmd_t c;
        c.wr  = wr;
        c.sel = reg_sel_e'(addr);
        return c;
    endfunction

endpackage

// File: rtl/trc_write_guard.sv
module trc_write_guard
    import thread_run_pkg::*;
#(
    parameter int NT = 8,
    parameter int DW = 16
) (
    input  reg_cmd_t        cmd,
    input  logic [DW-1:0]   wdata,
    output logic            accept,
    output logic [NT-1:0]   mask
);
    // Only the thread bits matter; upper data bits are dropped here.
    assign mask   = wdata[NT-1:0];
    assign accept = cmd.wr && (cmd.sel == SEL_RUN) && (|mask);
endmodule

// File: rtl/trc_run_reg.sv
module trc_run_reg #(
    parameter int            NT       = 8,
    parameter logic [NT-1:0] RST_MASK = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [NT-1:0] mask,
    output logic [NT-1:0] run_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= RST_MASK;
        end else if (accept) begin
            run_en <= mask;
        end
    end
endmodule

// File: rtl/trc_status_track.sv
module trc_status_track #(
    parameter int            NT       = 8,
    parameter logic [NT-1:0] RST_MASK = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] parked_ack,
    output logic [NT-1:0] status
);
    for (genvar i = 0; i < NT; i++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= RST_MASK[i];
            end else begin
                status[i] <= ~parked_ack[i];
            end
        end
    end
endmodule

// File: rtl/trc_read_mux.sv
module trc_read_mux
    import thread_run_pkg::*;
#(
    parameter int NT = 8,
    parameter int DW = 16
) (
    input  reg_sel_e      sel,
    input  logic [NT-1:0] run_en,
    input  logic [NT-1:0] status,
    output logic [DW-1:0] rdata
);
    logic [NT-1:0] picked;

    always_comb begin
        unique case (sel)
            SEL_RUN:  picked = run_en;
            SEL_STAT: picked = status;
            default:  picked = run_en;
        endcase
    end

    if (DW > NT) begin : g_pad
        assign rdata = {{(DW-NT){1'b0}}, picked};
    end else begin : g_nopad
        assign rdata = picked;
    end
endmodule

// File: rtl/thread_run_ctrl.sv
module thread_run_ctrl
    import thread_run_pkg::*;
#(
    parameter int                  NTHREADS = 8,
    parameter int                  DATA_W   = 16,
    parameter logic [NTHREADS-1:0] RST_MASK = '1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NTHREADS-1:0] park_req,
    input  logic [NTHREADS-1:0] parked_ack
);
    if (RST_MASK == '0) begin : g_bad_mask
        $error("thread_run_ctrl: RST_MASK must enable at least one thread");
    end
    if (DATA_W < NTHREADS) begin : g_bad_width
        $error("thread_run_ctrl: DATA_W must cover NTHREADS");
    end

    reg_cmd_t              cmd;
    logic                  accept;
    logic [NTHREADS-1:0]   wmask;
    logic [NTHREADS-1:0]   run_en;
    logic [NTHREADS-1:0]   status_q;

    assign cmd = decode_cmd(reg_wr, reg_addr);

    trc_write_guard #(.NT(NTHREADS), .DW(DATA_W)) u_guard (
        .cmd    (cmd),
        .wdata  (reg_wdata),
        .accept (accept),
        .mask   (wmask)
    );

    trc_run_reg #(.NT(NTHREADS), .RST_MASK(RST_MASK)) u_run (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .mask   (wmask),
        .run_en (run_en)
    );

    trc_status_track #(.NT(NTHREADS), .RST_MASK(RST_MASK)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .parked_ack (parked_ack),
        .status     (status_q)
    );

    trc_read_mux #(.NT(NTHREADS), .DW(DATA_W)) u_rd (
        .sel    (cmd.sel),
        .run_en (run_en),
        .status (status_q),
        .rdata  (reg_rdata)
    );

    assign park_req = ~run_en;

endmodule

// File: rtl/trc_checker.sv
module trc_checker #(
    parameter int NT = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic          reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [NT-1:0] park_req,
    input logic [NT-1:0] parked_ack,
    input logic [NT-1:0] run_en,
    input logic [NT-1:0] status
);
    // R3
    never_all_parked_chk: assert property (@(posedge clk) disable iff (rst)
        run_en != '0);

    // R3
    zero_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && (reg_wdata[NT-1:0] == '0)) |=> $stable(run_en));

    // R2
    write_applied_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_addr && (reg_wdata[NT-1:0] != '0))
            |=> (run_en == $past(reg_wdata[NT-1:0])));

    // R5
    status_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (status == ~$past(parked_ack)));

    // R4
    park_req_matches_read_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_addr |-> (reg_rdata[NT-1:0] == ~park_req));

    // R8
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr) |=> $stable(run_en));

    if (DW > NT) begin : g_upper
        // R7
        upper_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
            reg_rdata[DW-1:NT] == '0);
    end
endmodule

bind thread_run_ctrl trc_checker #(.NT(NTHREADS), .DW(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .park_req   (park_req),
    .parked_ack (parked_ack),
    .run_en     (run_en),
    .status     (status_q)
);

// File: tb/tb_thread_run_ctrl.sv
`timescale 1ns/1ps
module tb_thread_run_ctrl;
    localparam int NT = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NT-1:0] park_req;
    logic [NT-1:0] parked_ack = '0;

    always #2 clk = ~clk;

    thread_run_ctrl #(.NTHREADS(NT), .DATA_W(DW)) dut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .park_req   (park_req),
        .parked_ack (parked_ack)
    );

    int            vectors = 0;
    int            miscompares = 0;
    bit            finished = 1'b0;
    logic [NT-1:0] m_run = '1;
    logic [NT-1:0] m_stat = '1;
    int            ack_cnt [NT];
    logic [DW-1:0] last_rd;
    logic [DW-1:0] last_pr;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural threads: each follows its park request after 2+3*i cycles.
    task automatic threads();
        for (int i = 0; i < NT; i++) begin
            if (parked_ack[i] !== park_req[i]) begin
                ack_cnt[i]++;
                if (ack_cnt[i] >= 2 + 3 * i) begin
                    parked_ack[i] = park_req[i];
                    ack_cnt[i] = 0;
                end
            end else begin
                ack_cnt[i] = 0;
            end
        end
    endtask

    task automatic step(input logic w, input logic a, input logic [DW-1:0] d);
        logic [NT-1:0] n_run;
        logic [NT-1:0] n_stat;
        logic [NT-1:0] inv;
        @(negedge clk);
        threads();
        reg_wr    = w;
        reg_addr  = a;
        reg_wdata = d;
        #1;
        last_rd = reg_rdata;
        last_pr = DW'(park_req);
        inv = ~m_run;
        check("R4 park_req per cycle", DW'(park_req), DW'(inv));
        if (a) check("R5 status per cycle", reg_rdata, DW'(m_stat));
        else   check("R10 run-enable per cycle", reg_rdata, DW'(m_run));
        n_run = m_run;
        if (w && !a && (d[NT-1:0] != '0)) n_run = d[NT-1:0];
        n_stat = ~parked_ack;
        @(posedge clk);
        m_run  = n_run;
        m_stat = n_stat;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, k[0], '0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) ack_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        step(1'b0, 1'b0, '0); check("R1 run-enable reset", last_rd, 16'h00FF);
        check("R1 park_req reset", last_pr, 16'h0000);
        step(1'b0, 1'b1, '0); check("R1 status reset", last_rd, 16'h00FF);

        // R2 thread 0 parks all others; same-cycle read sees old value
        step(1'b1, 1'b0, 16'h0001); check("R2 old value on write cycle", last_rd, 16'h00FF);
        step(1'b0, 1'b1, '0); check("R5 status lags park", last_rd, 16'h00FF);
        check("R4 park_req after write", last_pr, 16'h00FE);
        idle(40);
        step(1'b0, 1'b1, '0); check("R6 status settled", last_rd, 16'h0001);
        step(1'b0, 1'b0, '0); check("R6 run-enable settled", last_rd, 16'h0001);

        // R3 all-zero write ignored
        step(1'b1, 1'b0, 16'h0000);
        step(1'b0, 1'b0, '0); check("R3 run-enable kept", last_rd, 16'h0001);
        step(1'b0, 1'b1, '0); check("R3 status kept", last_rd, 16'h0001);

        // R7 upper bits only -> treated as zero; upper bits dropped
        step(1'b1, 1'b0, 16'h0300);
        step(1'b0, 1'b0, '0); check("R7 upper-only write ignored", last_rd, 16'h0001);
        step(1'b1, 1'b0, 16'h0103);
        step(1'b0, 1'b0, '0); check("R7 upper bits dropped", last_rd, 16'h0003);
        idle(40);
        step(1'b0, 1'b1, '0); check("R6 status 03", last_rd, 16'h0003);

        // R8 write to status address ignored
        step(1'b1, 1'b1, 16'h00F0);
        step(1'b0, 1'b0, '0); check("R8 run-enable unchanged", last_rd, 16'h0003);

        // R2 thread 1 parks thread 0 and the rest
        step(1'b1, 1'b0, 16'h0002);
        step(1'b0, 1'b0, '0); check("R2 mask 02 loaded", last_rd, 16'h0002);
        check("R4 park_req FD", last_pr, 16'h00FD);
        idle(40);
        step(1'b0, 1'b1, '0); check("R6 status 02", last_rd, 16'h0002);

        // R9 unpark all
        step(1'b1, 1'b0, 16'h00FF);
        step(1'b0, 1'b1, '0); check("R9 park_req cleared", last_pr, 16'h0000);
        idle(40);
        step(1'b0, 1'b1, '0); check("R9 status restored", last_rd, 16'h00FF);

        // Overlapping changes while threads are draining
        step(1'b1, 1'b0, 16'h00A5);
        step(1'b0, 1'b1, '0);
        step(1'b1, 1'b0, 16'h005A);
        idle(40);
        step(1'b0, 1'b1, '0); check("R6 status 5A", last_rd, 16'h005A);
        step(1'b0, 1'b0, '0); check("R10 run-enable 5A", last_rd, 16'h005A);

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end
endmodule